// File: doc/BRIEF.md
# Path Signal Label Monitor

This block watches the signal label byte that arrives in the path overhead once per frame, for one path channel. Each received label is qualified by a frame strobe. A label is taken into the accepted-label register only after the same value has arrived on a programmable number of consecutive frames. This keeps a single corrupted byte from disturbing the stored label.

Two path defects run alongside the label filter. The unequipped defect tracks labels of value zero. The payload-mismatch defect tracks labels that differ from a programmable expected value. Each defect both sets and clears only after an unbroken run of frames that supports the change.

While the pointer is lost or path AIS is present, all monitoring is frozen. A payload-pass enable tells the downstream data path whether to forward payload, based on whether the accepted label equals the expected one.

Top module: `path_label_mon`

## Requirements
- R1: A synchronous active-high reset sets the accepted label to 0x00, clears the candidate and both defect run counts, and drives both defect flags low.
- R2: A label is monitored when the frame strobe is high and both the pointer-loss and path-AIS inputs are low. When a monitored label completes a run of N consecutive identical monitored values, it becomes the accepted label, visible on the cycle after the strobe. N is the 4-bit persistence setting, and a setting of 0 acts as 1. The run count saturates at 15.
- R3: A monitored label that differs from the current candidate becomes the new candidate, with a run count of 1.
- R4: A strobed frame with pointer loss or path AIS active changes no label or defect state.
- R5: The unequipped flag rises after N consecutive monitored labels equal to 0x00.
- R6: The unequipped flag falls after N consecutive monitored labels not equal to 0x00.
- R7: The mismatch flag rises after N consecutive monitored labels differing from the expected label.
- R8: The mismatch flag falls after N consecutive monitored labels equal to the expected label.
- R9: A monitored label that agrees with a defect flag's present state resets that defect's run count to zero.
- R10: The payload-pass output is high exactly when the accepted label equals the expected label input, with no added cycle in the default configuration.
- R11: Cycles without a frame strobe change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb_i | input | 1 | Frame strobe qualifying the label byte |
| lbl_i | input | 8 | Received signal label byte |
| persist_i | input | 4 | Consecutive-frame count for acceptance and defects |
| expect_i | input | 8 | Expected (provisioned) label |
| ptr_lost_i | input | 1 | Pointer-loss state from pointer processing |
| path_ais_i | input | 1 | Path AIS state |
| accepted_o | output | 8 | Accepted label |
| uneq_o | output | 1 | Unequipped path defect |
| plm_o | output | 1 | Payload label mismatch defect |
| pass_o | output | 1 | Payload forwarding enable |

## Verification
The hardest case to reach is a long run at the top persistence setting. This is a run of fifteen identical monitored labels, while alarm frames and strobe-free cycles are interleaved, which must neither advance nor break the run. The stimulus sweeps every persistence value from 0 to 15. It draws labels from a small alphabet in which most frames repeat the previous label, so long runs occur often. Pointer-loss, AIS and missing strobes are sprinkled in. A mid-sweep reset, and an expected label of 0x00 that makes both defects watch the same value, cover the overlap cases.

// File: rtl/path_label_pkg.sv
package path_label_pkg;

   typedef enum int unsigned {
      DEF_UNEQ = 0,
      DEF_PLM  = 1
   } defect_e;

   localparam int unsigned DEF_NUM = 2;

endpackage

// File: rtl/label_persist.sv
module label_persist #(
   parameter int unsigned LBL_W = 8,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mon_i,
   input  logic [LBL_W-1:0] lbl_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic [LBL_W-1:0] acc_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [LBL_W-1:0] cand_q;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_nxt;
   logic [LBL_W-1:0] acc_q;

   always_comb begin
      if (lbl_i != cand_q)
         run_nxt = CNT_ONE;
      else if (run_q == CNT_MAX)
         run_nxt = CNT_MAX;
      else
         run_nxt = run_q + CNT_ONE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cand_q <= '0;
         run_q  <= '0;
         acc_q  <= '0;
      end else if (mon_i) begin
         cand_q <= lbl_i;
         run_q  <= run_nxt;
         if (run_nxt >= thr_i)
            acc_q <= lbl_i;
      end
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/run_defect.sv
module run_defect #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mon_i,
   input  logic             cond_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic             flag_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             flag_q;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_inc;

   assign run_inc = run_q + CNT_ONE;

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q <= 1'b0;
         run_q  <= '0;
      end else if (mon_i) begin
         if (cond_i == flag_q) begin
            run_q <= '0;
         end else if (run_inc >= thr_i) begin
            flag_q <= cond_i;
            run_q  <= '0;
         end else begin
            run_q <= run_inc;
         end
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/path_label_mon.sv
module path_label_mon #(
   parameter int unsigned LBL_W    = 8,
   parameter int unsigned CNT_W    = 4,
   parameter bit          PASS_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frm_stb_i,
   input  logic [LBL_W-1:0] lbl_i,
   input  logic [CNT_W-1:0] persist_i,
   input  logic [LBL_W-1:0] expect_i,
   input  logic             ptr_lost_i,
   input  logic             path_ais_i,
   output logic [LBL_W-1:0] accepted_o,
   output logic             uneq_o,
   output logic             plm_o,
   output logic             pass_o
);

   import path_label_pkg::*;

   if (LBL_W < 2 || LBL_W > 32) begin : g_bad_lbl_w
      $error("path_label_mon: LBL_W out of range");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt_w
      $error("path_label_mon: CNT_W out of range");
   end

   logic             mon;
   logic [CNT_W-1:0] thr;
   logic [DEF_NUM-1:0] cond;
   logic [DEF_NUM-1:0] flag;
   logic             match;

   assign mon = frm_stb_i & ~ptr_lost_i & ~path_ais_i;
   assign thr = (persist_i == '0) ? CNT_W'(1) : persist_i;

   assign cond[DEF_UNEQ] = (lbl_i == '0);
   assign cond[DEF_PLM]  = (lbl_i != expect_i);

   label_persist #(
      .LBL_W (LBL_W),
      .CNT_W (CNT_W)
   ) u_persist (
      .clk   (clk),
      .rst   (rst),
      .mon_i (mon),
      .lbl_i (lbl_i),
      .thr_i (thr),
      .acc_o (accepted_o)
   );

   for (genvar d = 0; d < DEF_NUM; d++) begin : g_defect
      run_defect #(
         .CNT_W (CNT_W)
      ) u_run (
         .clk    (clk),
         .rst    (rst),
         .mon_i  (mon),
         .cond_i (cond[d]),
         .thr_i  (thr),
         .flag_o (flag[d])
      );
   end

   assign uneq_o = flag[DEF_UNEQ];
   assign plm_o  = flag[DEF_PLM];

   assign match = (accepted_o == expect_i);

   if (PASS_REG) begin : g_pass_reg
      logic pass_q;
      always_ff @(posedge clk) begin
         if (rst) pass_q <= 1'b0;
         else     pass_q <= match;
      end
      assign pass_o = pass_q;
   end else begin : g_pass_comb
      assign pass_o = match;
   end

endmodule

// File: rtl/path_label_mon_chk.sv
module path_label_mon_chk #(
   parameter int unsigned LBL_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             frm_stb_i,
   input logic [LBL_W-1:0] lbl_i,
   input logic [LBL_W-1:0] expect_i,
   input logic             ptr_lost_i,
   input logic             path_ais_i,
   input logic [LBL_W-1:0] accepted_o,
   input logic             uneq_o,
   input logic             plm_o
);

   logic mon;
   assign mon = frm_stb_i & ~ptr_lost_i & ~path_ais_i;

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (accepted_o == '0) && !uneq_o && !plm_o);

   a_r4_r11_frozen: assert property (@(posedge clk) disable iff (rst)
      !mon |=> $stable(accepted_o) && $stable(uneq_o) && $stable(plm_o));

   a_r2_accept_src: assert property (@(posedge clk) disable iff (rst)
      !$stable(accepted_o) |-> $past(mon) && (accepted_o == $past(lbl_i)));

   a_r5_uneq_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(uneq_o) |-> $past(mon) && ($past(lbl_i) == '0));

   a_r6_uneq_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(uneq_o) |-> $past(mon) && ($past(lbl_i) != '0));

   a_r7_plm_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(plm_o) |-> $past(mon) && ($past(lbl_i) != $past(expect_i)));

   a_r8_plm_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(plm_o) |-> $past(mon) && ($past(lbl_i) == $past(expect_i)));

endmodule

bind path_label_mon path_label_mon_chk #(.LBL_W(LBL_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .frm_stb_i  (frm_stb_i),
   .lbl_i      (lbl_i),
   .expect_i   (expect_i),
   .ptr_lost_i (ptr_lost_i),
   .path_ais_i (path_ais_i),
   .accepted_o (accepted_o),
   .uneq_o     (uneq_o),
   .plm_o      (plm_o)
);

// File: tb/test_path_label_mon.sv
module test_path_label_mon;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       frm_stb_i = 1'b0;
   logic [7:0] lbl_i = '0;
   logic [3:0] persist_i = '0;
   logic [7:0] expect_i = '0;
   logic       ptr_lost_i = 1'b0;
   logic       path_ais_i = 1'b0;
   logic [7:0] accepted_o;
   logic       uneq_o, plm_o, pass_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference state
   logic [7:0] m_cand, m_acc;
   int         m_run, m_urun, m_prun;
   logic       m_uneq, m_plm;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   path_label_mon i_path_label_mon (
      .clk        (clk),
      .rst        (rst),
      .frm_stb_i  (frm_stb_i),
      .lbl_i      (lbl_i),
      .persist_i  (persist_i),
      .expect_i   (expect_i),
      .ptr_lost_i (ptr_lost_i),
      .path_ais_i (path_ais_i),
      .accepted_o (accepted_o),
      .uneq_o     (uneq_o),
      .plm_o      (plm_o),
      .pass_o     (pass_o)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_cand = '0; m_acc = '0; m_run = 0;
      m_uneq = 1'b0; m_plm = 1'b0; m_urun = 0; m_prun = 0;
   endtask

   task automatic model_defect(input logic cond, inout logic flag, inout int run, input int thr);
      if (cond == flag) run = 0;
      else if (run + 1 >= thr) begin flag = cond; run = 0; end
      else run = run + 1;
   endtask

   task automatic check_all(input string tag_a, input string tag_u, input string tag_p);
      chk(tag_a, accepted_o, m_acc);
      chk(tag_u, {7'd0, uneq_o}, {7'd0, m_uneq});
      chk(tag_p, {7'd0, plm_o}, {7'd0, m_plm});
      chk("R10", {7'd0, pass_o}, {7'd0, (m_acc == expect_i)});
   endtask

   task automatic frame(input logic stb, input logic [7:0] lbl, input logic lop, input logic ais);
      int thr;
      @(negedge clk);
      frm_stb_i = stb; lbl_i = lbl; ptr_lost_i = lop; path_ais_i = ais;
      @(negedge clk);
      frm_stb_i = 1'b0; ptr_lost_i = 1'b0; path_ais_i = 1'b0;
      thr = (persist_i == 0) ? 1 : int'(persist_i);
      if (stb && !lop && !ais) begin
         if (lbl == m_cand) m_run = (m_run == 15) ? 15 : m_run + 1;
         else begin m_cand = lbl; m_run = 1; end
         if (m_run >= thr) m_acc = lbl;
         model_defect(lbl == 8'h00, m_uneq, m_urun, thr);
         model_defect(lbl != expect_i, m_plm, m_prun, thr);
         check_all("R2/R3", "R5/R6/R9", "R7/R8/R9");
      end else if (!stb) begin
         check_all("R11", "R11", "R11");
      end else begin
         check_all("R4", "R4", "R4");
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      model_reset();
      check_all("R1", "R1", "R1");
      rst = 1'b0;
   endtask

   function automatic logic [15:0] step(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   initial begin : watchdog
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [7:0] prev;
      model_reset();
      repeat (3) @(negedge clk);
      check_all("R1", "R1", "R1");
      rst = 1'b0;

      // directed: persistence 3, ATM label expected
      persist_i = 4'd3; expect_i = 8'h13;
      frame(1, 8'h13, 0, 0);
      frame(1, 8'h13, 0, 0);
      chk("R2", accepted_o, 8'h00);
      frame(1, 8'h13, 1, 0);        // pointer lost: ignored (R4)
      frame(0, 8'h55, 0, 0);        // no strobe (R11)
      frame(1, 8'h13, 0, 0);
      chk("R2", accepted_o, 8'h13);
      chk("R10", {7'd0, pass_o}, 8'd1);
      frame(1, 8'h16, 0, 0);
      frame(1, 8'h13, 0, 0);        // breaks mismatch run (R9)
      chk("R9", {7'd0, plm_o}, 8'd0);

      // sweep all persistence settings
      for (int p = 0; p < 16; p++) begin
         persist_i = 4'(p);
         expect_i = (p % 3 == 0) ? 8'h00 : ((p % 3 == 1) ? 8'h13 : 8'h16);
         if (p == 8) do_reset();
         prev = 8'h00;
         for (int f = 0; f < 160; f++) begin
            logic [7:0] l;
            logic s, lo, ai;
            lfsr = step(lfsr); lfsr = step(lfsr); lfsr = step(lfsr);
            case (lfsr[2:0])
               3'd5: l = 8'h00;
               3'd6: l = expect_i;
               3'd7: l = 8'hA5;
               default: l = prev;
            endcase
            s  = (lfsr[6:3] != 4'd0);
            lo = (lfsr[9:7] == 3'd0);
            ai = (lfsr[12:10] == 3'd0);
            prev = l;
            frame(s, l, lo, ai);
         end
      end

      // saturation: persistence 15, long run of one value
      persist_i = 4'd15; expect_i = 8'h01;
      for (int f = 0; f < 20; f++) frame(1, 8'h01, 0, 0);
      chk("R2", accepted_o, 8'h01);
      do_reset();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule